// File: doc/BRIEF.md
# Set/Clear Mailbox Register Bank

This block holds a bank of 32-bit mailbox registers that processors use to signal one another. With the default sizing there are four cores and four mailboxes per core, so sixteen mailboxes in all. Mailbox `j` of core `c` has index `c*4 + j`. A sender posts bits into a mailbox without disturbing bits that other senders have already posted. The receiver reads the mailbox and then acknowledges exactly the bits it has handled.

Software reaches the bank over a simple single-access-per-cycle word bus. Two address windows each cover every mailbox. A write to the set window ORs the data into the addressed mailbox. A write to the clear window removes the bits that are 1 in the data. The clear window is also the only readable view. Every mailbox drives a pending flag that is high while any of its bits is set, and the interrupt router downstream consumes these flags.

Top module: `mbox_bank`

## Requirements
- R1: Mailbox index `i = core*MB_PER_CORE + j` is reached at byte offset `SET_BASE + 4*i` (0x80 + 4*i) in the set window and `CLR_BASE + 4*i` (0xC0 + 4*i) in the clear window. Bit `i` of `pending` belongs to mailbox `i`.
- R2: A write to the set window leaves the addressed mailbox equal to its old value OR the write data. No other mailbox changes.
- R3: A write to the clear window leaves the addressed mailbox equal to its old value AND NOT the write data. No other mailbox changes.
- R4: A read (`bus_valid=1`, `bus_write=0`) from the clear window puts the mailbox contents on `bus_rdata` at the next rising clock edge.
- R5: A read from any address in the set window returns zero on `bus_rdata` at the next edge.
- R6: `pending[i]` is 1 exactly when mailbox `i` is nonzero. It changes at the same clock edge that changes the mailbox.
- R7: An active-low reset clears every mailbox, all of `pending`, and `bus_rdata`.
- R8: Some accesses are unmapped: offsets below 0x80, offsets at 0x100 or above, and offsets whose two low bits are not zero. A write to an unmapped offset changes no mailbox. A read from one returns zero.
- R9: A write of all zeros to either window leaves the mailbox unchanged.
- R10: `bus_rdata` keeps its value in cycles that carry no read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_valid | input | 1 | An access is presented this cycle |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W (12) | Byte offset |
| bus_wdata | input | DATA_W (32) | Write data, full word only |
| bus_rdata | output | DATA_W (32) | Read data, registered |
| pending | output | N_CORES*MB_PER_CORE (16) | Per-mailbox nonzero flags |

## Verification
Each result is due one edge after the access that causes it. A write lands in the mailbox register at the edge that samples it, and `pending` follows in the same cycle because it is a reduction of that register. Read data is registered, so it also appears at that edge. The bench drives each access on a falling edge and removes it on the next falling edge. It samples `bus_rdata` and `pending` at that second falling edge, which is half a cycle after the one edge the result depends on. An idle cycle after a read then checks that the read data holds.

// File: rtl/mbox_pkg.sv
package mbox_pkg;

  // Which address window an access falls into.
  typedef enum logic [1:0] {
    WIN_NONE = 2'd0,
    WIN_SET  = 2'd1,
    WIN_CLR  = 2'd2
  } win_e;

  // Byte offset to word slot within a window; returns the slot number.
  function automatic int unsigned slot_of(input int unsigned offset,
                                          input int unsigned base);
    return (offset - base) >> 2;
  endfunction

  // True when offset lies inside [base, base + 4*count) and is word aligned.
  function automatic logic in_window(input int unsigned offset,
                                     input int unsigned base,
                                     input int unsigned count);
    return (offset[1:0] == 2'b00) && (offset >= base) &&
           (offset < base + 4 * count);
  endfunction

endpackage

// File: rtl/mbox_decode.sv
module mbox_decode
  import mbox_pkg::*;
#(
  parameter int          N_MBOX   = 16,
  parameter int          ADDR_W   = 12,
  parameter int unsigned SET_BASE = 32'h80,
  parameter int unsigned CLR_BASE = 32'hC0,
  localparam int         IDX_W    = (N_MBOX > 1) ? $clog2(N_MBOX) : 1
) (
  input  logic [ADDR_W-1:0] addr,
  output win_e              win,
  output logic [IDX_W-1:0]  idx
);

  logic [31:0] off32;
  assign off32 = 32'(addr);

  always_comb begin
    win = WIN_NONE;
    idx = '0;
    if (in_window(off32, SET_BASE, N_MBOX)) begin
      win = WIN_SET;
      idx = IDX_W'(slot_of(off32, SET_BASE));
    end else if (in_window(off32, CLR_BASE, N_MBOX)) begin
      win = WIN_CLR;
      idx = IDX_W'(slot_of(off32, CLR_BASE));
    end
  end

endmodule

// File: rtl/mbox_cell.sv
module mbox_cell #(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              set_en,
  input  logic              clr_en,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] q,
  output logic              pending
);

  function automatic logic [DATA_W-1:0] next_word(
    input logic [DATA_W-1:0] cur,
    input logic [DATA_W-1:0] data,
    input logic              do_set,
    input logic              do_clr);
    logic [DATA_W-1:0] r;
    r = cur;
    if (do_set) r = r | data;
    if (do_clr) r = r & ~data;
    return r;
  endfunction

  logic [DATA_W-1:0] q_next;
  assign q_next = next_word(q, wdata, set_en, clr_en);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= '0;
    else        q <= q_next;
  end

  assign pending = |q;

  assert_set_or_R2: assert property (@(posedge clk) disable iff (!rst_n)
    set_en |=> (q == ($past(q) | $past(wdata))));

  assert_clr_andn_R3: assert property (@(posedge clk) disable iff (!rst_n)
    clr_en |=> (q == ($past(q) & ~$past(wdata))));

  assert_idle_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!set_en && !clr_en) |=> $stable(q));

  assert_pend_rise_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (set_en && wdata != '0) |=> pending);

endmodule

// File: rtl/mbox_readback.sv
module mbox_readback #(
  parameter int N_MBOX = 16,
  parameter int DATA_W = 32,
  localparam int IDX_W = (N_MBOX > 1) ? $clog2(N_MBOX) : 1
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           rd_req,
  input  logic                           rd_hit,
  input  logic [IDX_W-1:0]               rd_idx,
  input  logic [N_MBOX-1:0][DATA_W-1:0]  words,
  output logic [DATA_W-1:0]              rdata
);

  logic [DATA_W-1:0] sel_word;
  always_comb begin
    sel_word = '0;
    for (int k = 0; k < N_MBOX; k++) begin
      if (rd_hit && rd_idx == IDX_W'(k)) sel_word = words[k];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      rdata <= '0;
    else if (rd_req) rdata <= sel_word;
  end

  assert_miss_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req && !rd_hit) |=> (rdata == '0));

  assert_rdata_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_req |=> $stable(rdata));

endmodule

// File: rtl/mbox_bank.sv
module mbox_bank
  import mbox_pkg::*;
#(
  parameter int          N_CORES     = 4,
  parameter int          MB_PER_CORE = 4,
  parameter int          DATA_W      = 32,
  parameter int          ADDR_W      = 12,
  parameter int unsigned SET_BASE    = 32'h80,
  parameter int unsigned CLR_BASE    = 32'hC0
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           bus_valid,
  input  logic                           bus_write,
  input  logic [ADDR_W-1:0]              bus_addr,
  input  logic [DATA_W-1:0]              bus_wdata,
  output logic [DATA_W-1:0]              bus_rdata,
  output logic [N_CORES*MB_PER_CORE-1:0] pending
);

  localparam int N_MBOX = N_CORES * MB_PER_CORE;
  localparam int IDX_W  = (N_MBOX > 1) ? $clog2(N_MBOX) : 1;

  win_e                         win;
  logic [IDX_W-1:0]             idx;
  logic                         wr_req;
  logic                         rd_req;
  logic [N_MBOX-1:0]            set_vec;
  logic [N_MBOX-1:0]            clr_vec;
  logic [N_MBOX-1:0][DATA_W-1:0] words;

  mbox_decode #(
    .N_MBOX  (N_MBOX),
    .ADDR_W  (ADDR_W),
    .SET_BASE(SET_BASE),
    .CLR_BASE(CLR_BASE)
  ) u_decode (
    .addr(bus_addr),
    .win (win),
    .idx (idx)
  );

  assign wr_req = bus_valid && bus_write;
  assign rd_req = bus_valid && !bus_write;

  // Mailbox i of core c lives at slot c*MB_PER_CORE + i.
  for (genvar c = 0; c < N_CORES; c++) begin : g_core
    for (genvar j = 0; j < MB_PER_CORE; j++) begin : g_box
      localparam int SLOT = c * MB_PER_CORE + j;
      assign set_vec[SLOT] = wr_req && (win == WIN_SET) && (idx == IDX_W'(SLOT));
      assign clr_vec[SLOT] = wr_req && (win == WIN_CLR) && (idx == IDX_W'(SLOT));

      mbox_cell #(.DATA_W(DATA_W)) u_cell (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_en (set_vec[SLOT]),
        .clr_en (clr_vec[SLOT]),
        .wdata  (bus_wdata),
        .q      (words[SLOT]),
        .pending(pending[SLOT])
      );
    end
  end

  mbox_readback #(.N_MBOX(N_MBOX), .DATA_W(DATA_W)) u_readback (
    .clk   (clk),
    .rst_n (rst_n),
    .rd_req(rd_req),
    .rd_hit(win == WIN_CLR),
    .rd_idx(idx),
    .words (words),
    .rdata (bus_rdata)
  );

  assert_single_target_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({set_vec, clr_vec}));

  assert_unmapped_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_req && win == WIN_NONE) |=> $stable(words));

  assert_zero_write_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_req && bus_wdata == '0) |=> $stable(words));

endmodule

// File: tb/mbox_bank_test.sv
module mbox_bank_test;

  localparam int N = 16;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_valid = 1'b0;
  logic        bus_write = 1'b0;
  logic [11:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [15:0] pending;

  int vectors = 0;
  int errors = 0;
  logic [31:0] model [N];

  always #4 clk = ~clk;

  mbox_bank uut (
    .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .pending(pending)
  );

  task automatic check(input string req, input logic [31:0] got,
                       input logic [31:0] exp);
    vectors++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  function automatic logic [15:0] exp_pending();
    logic [15:0] p;
    for (int k = 0; k < N; k++) p[k] = (model[k] != 32'h0);
    return p;
  endfunction

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_valid = 1'b1; bus_write = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_valid = 1'b0; bus_write = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_valid = 1'b1; bus_write = 1'b0; bus_addr = a;
    @(negedge clk);
    bus_valid = 1'b0;
    d = bus_rdata;
  endtask

  task automatic check_all(input string req);
    logic [31:0] v;
    for (int k = 0; k < N; k++) begin
      rd(12'h0C0 + 12'(4 * k), v);
      check(req, v, model[k]);
    end
    check(req, 32'(pending), 32'(exp_pending()));
  endtask

  initial begin
    #(8 * 200000);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    logic [31:0] v;
    logic [31:0] held;
    for (int k = 0; k < N; k++) model[k] = 32'h0;
    repeat (3) @(negedge clk);
    // R7: reset state
    check("R7 pending at reset", 32'(pending), 32'h0);
    check("R7 rdata at reset", bus_rdata, 32'h0);
    rst_n = 1'b1;
    check_all("R7 mailboxes after reset");

    // R2 R6 R1: post into each mailbox in turn; pending grows bit by bit
    for (int k = 0; k < N; k++) begin
      v = (32'hA5000000 ^ (32'(k) * 32'h01010101)) | (32'h1 << k);
      wr(12'h080 + 12'(4 * k), v);
      model[k] = model[k] | v;
      check("R6 R1 pending after set", 32'(pending), 32'(exp_pending()));
    end
    check_all("R4 R1 readback after first set");

    // R2: second set accumulates
    for (int k = 0; k < N; k++) begin
      v = 32'h80000000 >> k;
      wr(12'h080 + 12'(4 * k), v);
      model[k] = model[k] | v;
    end
    check_all("R2 OR accumulate");

    // R5 and R10: set-window reads return zero; rdata holds when idle
    rd(12'h0C0 + 12'd20, held);
    check("R4 read slot 5", held, model[5]);
    @(negedge clk);
    check("R10 rdata held", bus_rdata, held);
    for (int k = 0; k < N; k++) begin
      rd(12'h080 + 12'(4 * k), v);
      check("R5 set window reads zero", v, 32'h0);
    end

    // R9: zero writes to both windows
    wr(12'h080 + 12'd12, 32'h0);
    wr(12'h0C0 + 12'd12, 32'h0);
    check_all("R9 zero write no effect");

    // R8: unmapped writes and reads
    for (int a = 0; a < 12'h080; a += 4) wr(12'(a), 32'hFFFFFFFF);
    wr(12'h100, 32'hFFFFFFFF);
    wr(12'h1C0, 32'hFFFFFFFF);
    wr(12'h0C1, 32'hFFFFFFFF);
    wr(12'h0C6, 32'hFFFFFFFF);
    wr(12'h083, 32'h0000FFFF);
    check_all("R8 unmapped write ignored");
    rd(12'h040, v); check("R8 read low offset", v, 32'h0);
    rd(12'h100, v); check("R8 read past end", v, 32'h0);
    rd(12'h0C2, v); check("R8 read misaligned", v, 32'h0);

    // R3: partial clears
    for (int k = 0; k < N; k++) begin
      v = 32'h00FF00FF << (k % 8);
      wr(12'h0C0 + 12'(4 * k), v);
      model[k] = model[k] & ~v;
    end
    check_all("R3 partial clear");

    // R3 R6: clear everything, pending falls one bit at a time
    for (int k = 0; k < N; k++) begin
      wr(12'h0C0 + 12'(4 * k), 32'hFFFFFFFF);
      model[k] = 32'h0;
      check("R6 pending after full clear", 32'(pending), 32'(exp_pending()));
    end

    // R7: reset mid-run
    wr(12'h080, 32'h12345678);
    wr(12'h0BC, 32'h00000001);
    rd(12'h0C0, v);
    check("R4 read slot 0", v, 32'h12345678);
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    check("R7 pending during reset", 32'(pending), 32'h0);
    check("R7 rdata during reset", bus_rdata, 32'h0);
    rst_n = 1'b1;
    model[0] = 32'h0;
    model[15] = 32'h0;
    check_all("R7 mailboxes after mid-run reset");

    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

endmodule